// File: doc/BRIEF.md
# Triggered Event Readout Sequencer

This block moves one event from a set of TDC chips into a readout FIFO each time a level-2 accept arrives. When the accept is seen, the ready flag drops at once. The block then latches the buffer number, the bunch crossing identifier and the chip selection mask. It visits the selected chips in ascending index order and passes each hit word to the FIFO in the same cycle the chip presents it. Hit words are never staged inside the block.

Because nothing is staged, the event header cannot go first. The block appends the header after the last data word. In the same cycle it copies the data-word count into a count register, so the crate controller can read the count before it drains the FIFO. The ready flag then rises again and the block waits for the next accept. A full FIFO stalls the block without losing words. One accept that arrives while an event is in progress is remembered and served next.

Top module: `evt_readout_seq`

## Requirements
- R1: After reset, `local_done_o` is 1, `fifo_wr_o` is 0 and `word_count_o` is 0.
- R2: In any cycle where `l2a_i` is 1, `local_done_o` is 0 in that same cycle.
- R3: The buffer number, bunch identifier and chip mask are sampled in the accept cycle (or in the cycle a pending accept is taken). Later changes on those inputs do not affect that event.
- R4: Chip k is read only when bit k of the captured mask is 1 (1 = read, 0 = skip). Selected chips are read in ascending index order, and `hit_rdy_o` is never raised with `hit_sel_o` on a skipped chip.
- R5: A hit word is written to the FIFO unchanged, in the cycle where `hit_vld_i` and `hit_rdy_o` are both 1. Each data word is written exactly once.
- R6: `hit_eoc_i` seen while `hit_rdy_o` is 1 closes the current chip. A chip may close with zero words.
- R7: Exactly one header word is written after the last data word of each event. Its layout is: bits [31:28] buffer number, [27:20] bunch identifier, [19:12] zero, [11:0] data-word count.
- R8: `word_count_o` takes the event's data-word count in the header write cycle and holds it until the next header write.
- R9: `local_done_o` is 1 in the cycle after the header write, unless an accept is present in that cycle.
- R10: While `fifo_full_i` is 1, `fifo_wr_o` is 0 and the sequence holds. No word is lost or duplicated.
- R11: An accept that arrives while an event is in progress is kept, together with its own buffer, bunch and mask values. It is served right after the current header. Further accepts that arrive while one is already pending are dropped.
- R12: An all-zero mask produces only a header with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l2a_i | input | 1 | Level-2 accept strobe |
| buf_num_i | input | 4 | Buffer number for the header |
| bunch_id_i | input | 8 | Bunch crossing identifier for the header |
| scan_mask_i | input | 4 | Chip selection, 1 = read |
| hit_sel_o | output | 2 | Index of the chip being read |
| hit_rdy_o | output | 1 | Block accepts a word or end marker |
| hit_vld_i | input | 1 | Selected chip presents a hit word |
| hit_eoc_i | input | 1 | Selected chip has no more words |
| hit_word_i | input | 32 | Hit word from selected chip |
| fifo_full_i | input | 1 | Readout FIFO cannot take a word |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 32 | FIFO write data |
| local_done_o | output | 1 | Event complete and block ready |
| word_count_o | output | 12 | Data-word count of the last event |

## Verification
The hardest case to reach from the ports is a second accept that lands mid-event while the FIFO is applying backpressure and the chips leave gaps. Its buffer, bunch and mask must survive until the first header has been written. The bench gets there by preloading each chip model with the words of both events, each event closed by its own end marker. It then pulses the second accept a few cycles into the first event and changes the capture inputs right after each pulse. The scoreboard expects the first event's data and header, then the second's, in that order.

// File: rtl/ers_pkg.sv
package ers_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_READ,
    ST_HDR
  } seq_st_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ers_pick.sv
// Lowest-set-bit selector over the chips still to be visited.
module ers_pick #(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [N_CHIPS-1:0] todo_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_CHIPS-1:0] onehot_o
);

  logic [N_CHIPS-1:0] below_seen;

  assign any_o = |todo_i;

  // below_seen[k] is set when some lower chip is still pending
  generate
    for (genvar k = 0; k < N_CHIPS; k++) begin : g_scan
      if (k == 0) begin : g_first
        assign below_seen[k] = 1'b0;
      end else begin : g_rest
        assign below_seen[k] = below_seen[k-1] | todo_i[k-1];
      end
      assign onehot_o[k] = todo_i[k] & ~below_seen[k];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(N_CHIPS); i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/ers_fsm.sv
// Event sequencing: accept handling, pending slot, chip walk, header slot.
module ers_fsm
  import ers_pkg::*;
#(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned BUF_W   = 4,
  parameter int unsigned BX_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l2a_i,
  input  logic [BUF_W-1:0]   buf_i,
  input  logic [BX_W-1:0]    bx_i,
  input  logic [N_CHIPS-1:0] mask_i,
  input  logic               hit_vld_i,
  input  logic               hit_eoc_i,
  input  logic               fifo_full_i,
  input  logic               pick_any_i,
  input  logic [N_CHIPS-1:0] pick_oh_i,
  input  logic [IDX_W-1:0]   pick_idx_i,
  output logic [N_CHIPS-1:0] todo_o,
  output logic [IDX_W-1:0]   cur_idx_o,
  output logic [BUF_W-1:0]   ev_buf_o,
  output logic [BX_W-1:0]    ev_bx_o,
  output logic               done_q_o,
  output logic               start_evt_o,
  output logic               hit_rdy_o,
  output logic               hit_take_o,
  output logic               hdr_wr_o
);

  seq_st_e            state_q;
  logic [N_CHIPS-1:0] todo_q;
  logic [N_CHIPS-1:0] ev_mask_q;
  logic [IDX_W-1:0]   cur_idx_q;
  logic [BUF_W-1:0]   ev_buf_q;
  logic [BX_W-1:0]    ev_bx_q;
  logic               done_q;

  logic               pend_q;
  logic [BUF_W-1:0]   pend_buf_q;
  logic [BX_W-1:0]    pend_bx_q;
  logic [N_CHIPS-1:0] pend_mask_q;

  // named internal events
  logic in_idle, in_read, in_hdr;
  logic idle_go, chip_end, park_accept;
  logic [N_CHIPS-1:0] start_mask;

  assign in_idle     = (state_q == ST_IDLE);
  assign in_read     = (state_q == ST_READ);
  assign in_hdr      = (state_q == ST_HDR);
  assign idle_go     = in_idle && (pend_q || l2a_i);
  assign hit_rdy_o   = in_read && !fifo_full_i;
  assign hit_take_o  = hit_rdy_o && hit_vld_i;
  assign chip_end    = hit_rdy_o && hit_eoc_i;
  assign hdr_wr_o    = in_hdr && !fifo_full_i;
  assign park_accept = l2a_i && !in_idle && !pend_q;
  assign start_mask  = pend_q ? pend_mask_q : mask_i;
  assign start_evt_o = idle_go;

  // capture of event parameters and the single pending slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_buf_q    <= '0;
      ev_bx_q     <= '0;
      ev_mask_q   <= '0;
      pend_q      <= 1'b0;
      pend_buf_q  <= '0;
      pend_bx_q   <= '0;
      pend_mask_q <= '0;
    end else if (in_idle && pend_q) begin
      ev_buf_q  <= pend_buf_q;
      ev_bx_q   <= pend_bx_q;
      ev_mask_q <= pend_mask_q;
      pend_q    <= l2a_i;
      if (l2a_i) begin
        pend_buf_q  <= buf_i;
        pend_bx_q   <= bx_i;
        pend_mask_q <= mask_i;
      end
    end else if (in_idle && l2a_i) begin
      ev_buf_q  <= buf_i;
      ev_bx_q   <= bx_i;
      ev_mask_q <= mask_i;
    end else if (park_accept) begin
      pend_q      <= 1'b1;
      pend_buf_q  <= buf_i;
      pend_bx_q   <= bx_i;
      pend_mask_q <= mask_i;
    end
  end

  // sequence through chips and the header slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      todo_q    <= '0;
      cur_idx_q <= '0;
      done_q    <= 1'b1;
    end else begin
      if (idle_go)       done_q <= 1'b0;
      else if (hdr_wr_o) done_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: if (idle_go) begin
          todo_q  <= start_mask;
          state_q <= ST_SEEK;
        end
        ST_SEEK: if (pick_any_i) begin
          cur_idx_q <= pick_idx_i;
          todo_q    <= todo_q & ~pick_oh_i;
          state_q   <= ST_READ;
        end else begin
          state_q <= ST_HDR;
        end
        ST_READ: if (chip_end) state_q <= ST_SEEK;
        ST_HDR:  if (hdr_wr_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign todo_o    = todo_q;
  assign cur_idx_o = cur_idx_q;
  assign ev_buf_o  = ev_buf_q;
  assign ev_bx_o   = ev_bx_q;
  assign done_q_o  = done_q;

  // R4
  skip_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rdy_o |-> ev_mask_q[cur_idx_q]);

  // R10
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && fifo_full_i) |=> (in_read && $stable(cur_idx_q)));

  // R9
  done_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr_o |=> done_q);

  // R2
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2a_i && !in_hdr) |=> !done_q);

  // R11
  pend_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_wr_o && pend_q) |=> ##1 (state_q == ST_SEEK));

endmodule

// File: rtl/ers_hdr.sv
// Data-word tally, header packing and the published count register.
module ers_hdr #(
  parameter int unsigned BUF_W  = 4,
  parameter int unsigned BX_W   = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt_i,
  input  logic              hit_take_i,
  input  logic              hdr_wr_i,
  input  logic [BUF_W-1:0]  ev_buf_i,
  input  logic [BX_W-1:0]   ev_bx_i,
  output logic [DATA_W-1:0] header_o,
  output logic [CNT_W-1:0]  wc_o
);

  localparam int unsigned PAD_W = DATA_W - BUF_W - BX_W - CNT_W;

  function automatic logic [DATA_W-1:0] pack_header(
    input logic [BUF_W-1:0] b,
    input logic [BX_W-1:0]  x,
    input logic [CNT_W-1:0] n
  );
    return {b, x, {PAD_W{1'b0}}, n};
  endfunction

  logic [CNT_W-1:0] run_cnt_q;
  logic [CNT_W-1:0] wc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           run_cnt_q <= '0;
    else if (start_evt_i) run_cnt_q <= '0;
    else if (hit_take_i)  run_cnt_q <= run_cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        wc_q <= '0;
    else if (hdr_wr_i) wc_q <= run_cnt_q;
  end

  assign header_o = pack_header(ev_buf_i, ev_bx_i, run_cnt_q);
  assign wc_o     = wc_q;

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_wr_i |=> $stable(wc_q));

endmodule

// File: rtl/evt_readout_seq.sv
module evt_readout_seq
  import ers_pkg::*;
#(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned BUF_W   = 4,
  parameter int unsigned BX_W    = 8,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = idx_width(N_CHIPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l2a_i,
  input  logic [BUF_W-1:0]   buf_num_i,
  input  logic [BX_W-1:0]    bunch_id_i,
  input  logic [N_CHIPS-1:0] scan_mask_i,
  output logic [IDX_W-1:0]   hit_sel_o,
  output logic               hit_rdy_o,
  input  logic               hit_vld_i,
  input  logic               hit_eoc_i,
  input  logic [DATA_W-1:0]  hit_word_i,
  input  logic               fifo_full_i,
  output logic               fifo_wr_o,
  output logic [DATA_W-1:0]  fifo_wdata_o,
  output logic               local_done_o,
  output logic [CNT_W-1:0]   word_count_o
);

  logic [N_CHIPS-1:0] todo;
  logic               pick_any;
  logic [N_CHIPS-1:0] pick_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic [IDX_W-1:0]   cur_idx;
  logic [BUF_W-1:0]   ev_buf;
  logic [BX_W-1:0]    ev_bx;
  logic               done_q;
  logic               start_evt;
  logic               hit_take;
  logic               hdr_wr;
  logic [DATA_W-1:0]  header;

  ers_pick #(.N_CHIPS(N_CHIPS), .IDX_W(IDX_W)) u_pick (
    .todo_i   (todo),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  ers_fsm #(.N_CHIPS(N_CHIPS), .IDX_W(IDX_W), .BUF_W(BUF_W), .BX_W(BX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .l2a_i       (l2a_i),
    .buf_i       (buf_num_i),
    .bx_i        (bunch_id_i),
    .mask_i      (scan_mask_i),
    .hit_vld_i   (hit_vld_i),
    .hit_eoc_i   (hit_eoc_i),
    .fifo_full_i (fifo_full_i),
    .pick_any_i  (pick_any),
    .pick_oh_i   (pick_oh),
    .pick_idx_i  (pick_idx),
    .todo_o      (todo),
    .cur_idx_o   (cur_idx),
    .ev_buf_o    (ev_buf),
    .ev_bx_o     (ev_bx),
    .done_q_o    (done_q),
    .start_evt_o (start_evt),
    .hit_rdy_o   (hit_rdy_o),
    .hit_take_o  (hit_take),
    .hdr_wr_o    (hdr_wr)
  );

  ers_hdr #(.BUF_W(BUF_W), .BX_W(BX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_hdr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt_i (start_evt),
    .hit_take_i  (hit_take),
    .hdr_wr_i    (hdr_wr),
    .ev_buf_i    (ev_buf),
    .ev_bx_i     (ev_bx),
    .header_o    (header),
    .wc_o        (word_count_o)
  );

  assign hit_sel_o    = cur_idx;
  assign fifo_wr_o    = hit_take | hdr_wr;
  assign fifo_wdata_o = hdr_wr ? header : hit_word_i;
  assign local_done_o = done_q & ~l2a_i;

  // R10
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full_i |-> !fifo_wr_o);

  // R7
  hdr_not_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> !(hit_take && hdr_wr));

endmodule

// File: tb/sim_evt_readout_seq.sv
module sim_evt_readout_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l2a_i = 1'b0;
  logic [3:0]  buf_num_i = '0;
  logic [7:0]  bunch_id_i = '0;
  logic [3:0]  scan_mask_i = '0;
  logic [1:0]  hit_sel_o;
  logic        hit_rdy_o;
  logic        hit_vld_i = 1'b0;
  logic        hit_eoc_i = 1'b0;
  logic [31:0] hit_word_i = '0;
  logic        fifo_full_i = 1'b0;
  logic        fifo_wr_o;
  logic [31:0] fifo_wdata_o;
  logic        local_done_o;
  logic [11:0] word_count_o;

  always #4 clk = ~clk;

  evt_readout_seq u0 (.*);

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  int unsigned cyc = 0;

  logic [32:0] cq [4][$];
  logic [32:0] expq [$];
  logic [3:0]  read_ok = '0;
  logic        full_noise = 1'b0;
  logic        gap_noise = 1'b0;
  logic [7:0]  lf = 8'h5B;
  logic        gap = 1'b0;
  logic        will_pop = 1'b0;
  logic [1:0]  pop_sel = '0;
  logic        hdr_pend = 1'b0;
  logic [11:0] hdr_cnt = '0;
  int unsigned last_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  // chip source model: pops at the edge, presents after it
  always begin
    @(posedge clk);
    cyc++;
    if (will_pop && cq[pop_sel].size() > 0) void'(cq[pop_sel].pop_front());
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    fifo_full_i = full_noise & lf[0] & lf[3];
    gap = gap_noise & lf[2] & lf[6];
    hit_vld_i = 1'b0;
    hit_eoc_i = 1'b0;
    hit_word_i = 32'h0;
    if (cq[hit_sel_o].size() > 0 && !gap) begin
      if (cq[hit_sel_o][0][32]) hit_eoc_i = 1'b1;
      else begin
        hit_vld_i = 1'b1;
        hit_word_i = cq[hit_sel_o][0][31:0];
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      will_pop = hit_rdy_o && (hit_vld_i || hit_eoc_i);
      pop_sel = hit_sel_o;
      // R4: never ready on a chip outside the outstanding masks
      if (hit_rdy_o && !read_ok[hit_sel_o]) check(1'b0, "R4", {30'b0, hit_sel_o}, {28'b0, read_ok});
      if (hdr_pend) begin
        check(local_done_o == 1'b1, "R9", {31'b0, local_done_o}, 32'h1);
        check(word_count_o == hdr_cnt, "R8", {20'b0, word_count_o}, {20'b0, hdr_cnt});
        hdr_pend = 1'b0;
      end
      if (fifo_wr_o) begin
        // R10: a write under full would be a lost/duplicated word
        if (fifo_full_i) check(1'b0, "R10", 32'h1, 32'h0);
        if (expq.size() == 0) check(1'b0, "R5 unexpected write", fifo_wdata_o, 32'h0);
        else begin
          logic [32:0] e;
          e = expq.pop_front();
          if (e[32]) begin
            check(fifo_wdata_o == e[31:0], "R7 header", fifo_wdata_o, e[31:0]);
            hdr_pend = 1'b1;
            hdr_cnt = e[11:0];
          end else begin
            check(fifo_wdata_o == e[31:0], "R5 R10 data", fifo_wdata_o, e[31:0]);
          end
        end
      end
    end
  end

  task automatic load_evt(input logic [3:0] mask, input logic [3:0] bv, input logic [7:0] bx,
                          input int n0, input int n1, input int n2, input int n3, input logic [3:0] tag);
    int n[4];
    int cnt;
    n[0] = n0; n[1] = n1; n[2] = n2; n[3] = n3;
    cnt = 0;
    for (int c = 0; c < 4; c++) begin
      if (mask[c]) begin
        for (int i = 0; i < n[c]; i++) begin
          logic [31:0] w;
          w = {4'(c), tag, 8'hD0, 16'(i)};
          cq[c].push_back({1'b0, w});
          expq.push_back({1'b0, w});
          cnt++;
        end
        cq[c].push_back({1'b1, 32'h0});
      end
    end
    // header: buffer at bit 28, bunch at bit 20, count in low 12 bits
    expq.push_back({1'b1, (32'(bv) << 28) | (32'(bx) << 20) | 32'(cnt)});
    read_ok = read_ok | mask;
    last_cnt = cnt;
  endtask

  task automatic pulse_l2a(input logic [3:0] mask, input logic [3:0] bv, input logic [7:0] bx);
    @(posedge clk); #1;
    l2a_i = 1'b1; scan_mask_i = mask; buf_num_i = bv; bunch_id_i = bx;
    #1;
    check(local_done_o == 1'b0, "R2", {31'b0, local_done_o}, 32'h0);
    @(posedge clk); #1;
    l2a_i = 1'b0;
    // R3: scramble capture inputs after the accept
    scan_mask_i = ~mask; buf_num_i = ~bv; bunch_id_i = ~bx;
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    while (!(local_done_o && expq.size() == 0) && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 4000, "R9 completion", 32'(guard), 32'd4000);
    check(word_count_o == 12'(last_cnt), "R8 final count", {20'b0, word_count_o}, 32'(last_cnt));
    @(negedge clk);
    read_ok = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(local_done_o == 1'b1, "R1 done", {31'b0, local_done_o}, 32'h1);
    check(fifo_wr_o == 1'b0, "R1 wr", {31'b0, fifo_wr_o}, 32'h0);
    check(word_count_o == 12'h0, "R1 count", {20'b0, word_count_o}, 32'h0);

    // R3 R4: chip 2 skipped, inputs scrambled after accept
    load_evt(4'b1011, 4'h3, 8'h5A, 3, 2, 0, 1, 4'h1);
    pulse_l2a(4'b1011, 4'h3, 8'h5A);
    wait_done();

    // R6 R10: all chips, chip 1 closes empty, backpressure and gaps
    full_noise = 1'b1; gap_noise = 1'b1;
    load_evt(4'b1111, 4'hC, 8'hA7, 4, 0, 5, 2, 4'h2);
    pulse_l2a(4'b1111, 4'hC, 8'hA7);
    wait_done();

    // R12: empty mask gives header only
    load_evt(4'b0000, 4'h9, 8'h11, 0, 0, 0, 0, 4'h3);
    pulse_l2a(4'b0000, 4'h9, 8'h11);
    wait_done();

    // R11: second accept parked during the first event
    load_evt(4'b0101, 4'h6, 8'h3C, 6, 0, 4, 0, 4'h4);
    load_evt(4'b1010, 4'hE, 8'hC3, 0, 3, 0, 7, 4'h5);
    pulse_l2a(4'b0101, 4'h6, 8'h3C);
    repeat (3) @(posedge clk);
    pulse_l2a(4'b1010, 4'hE, 8'hC3);
    wait_done();
    full_noise = 1'b0; gap_noise = 1'b0;

    check(expq.size() == 0, "R7 leftover", 32'(expq.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    check(1'b0, "R9 watchdog", 32'(cyc), 32'd20000);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule